// File: doc/BRIEF.md
# Two-Wire Module-Identification Memory Target

This block is a target on a two-wire serial bus. It holds a 256 x 8 identification memory that a host reads while it sets up a memory module. The SCL and SDA inputs are sampled by the block's own fast clock through a short synchroniser. The block pulls SDA low through an open-drain enable. Three select pins set the device's bus identity, so eight copies can share one bus. The block supports single-byte writes, reads from the current address, random reads and sequential reads.

A write to the memory takes effect only when the host sends a stop condition. The write then starts a busy interval, and during that interval the device ignores every addressing attempt. There are two write guards, one for each half of the address space. The lower half can be locked by a one-time flag, which is set by a write that uses a second device-type code. The upper half is guarded by a write-protect pin. A write that hits a guarded region still completes its bus handshake, but it changes nothing and starts no busy interval.

Top module: `spd_eeprom_target`

## Requirements
- R1: After reset the block does not drive SDA. A start condition (SDA falls while SCL is high) must come first: address bits clocked without a start are not acknowledged. A stop condition (SDA rises while SCL is high) ends any transfer.
- R2: The first byte after a start is acknowledged only if bits 7..4 hold the memory code 1010 and bits 3..1 equal the select pins sel_i[2:0]. Any other code or select value gets no acknowledge.
- R3: Bit 0 of the first byte selects the direction (0 = write, 1 = read). A write sends the word address and then one data byte, and the memory changes only when the stop arrives. A repeated start before the stop discards the pending byte.
- R4: A random read is a write phase that carries only the word address, then a repeated start and a read. It returns the byte stored at that address.
- R5: During a read, the address pointer advances after every byte sent. It wraps from FFh to 00h. The read ends when the host answers a byte with no acknowledge.
- R6: A read that has no address phase (current-address read) continues from the pointer left by the previous access.
- R7: A committed write starts a busy interval of BUSY_CYCLES clocks. During that interval no first byte is acknowledged. After the interval, addressing works again.
- R8: A write with code 0110 in bits 7..4, the matching select bits and bit 0 = 0, followed by one byte and a stop, sets a lock flag. The flag cannot be cleared. While it is set, writes to 00h..7Fh are blocked, and writes to 80h..FFh are not affected by it.
- R9: While wp_i is high, writes to 80h..FFh are blocked. While wp_i is low, they are allowed.
- R10: A blocked write (including a repeat of the lock write once the flag is set) acknowledges every byte, leaves the memory unchanged and starts no busy interval.
- R11: Code 0110 with bit 0 = 1 gets no acknowledge. In a write, a second data byte after the first gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sel_i | input | 3 | Device select pins, compared with first-byte bits 3..1 |
| wp_i | input | 1 | Write-protect pin for the upper half (low = writable) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |

## Verification
Write commits are tried in four guard settings: unguarded, upper half with the pin high, lower half with the flag set, and upper half with the flag set. This tells apart the two guard mechanisms and shows that each guards only its own half. Reads are tried as random, sequential across the FFh-to-00h boundary, and current-address. This separates pointer loading, pointer advance and wraparound. Each write is followed at once by an addressing probe. This separates commits that start the busy interval from blocked or discarded writes that must not start it. Wrong select bits, a wrong code and bits without a start check the addressing filter.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WORD, ST_DATA, ST_LOCKB, ST_TX, ST_HOLD
  } bus_state_t;

  localparam logic [3:0] CODE_MEM  = 4'b1010;
  localparam logic [3:0] CODE_LOCK = 4'b0110;

  // lower half guarded by the one-time flag, upper half by the pin
  function automatic logic write_allowed(input logic lock, input logic wp,
                                         input logic upper);
    return upper ? !wp : !lock;
  endfunction

  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] sel);
    logic sel_ok;
    sel_ok = (b[3:1] == sel);
    return sel_ok && ((b[7:4] == CODE_MEM) ||
                      ((b[7:4] == CODE_LOCK) && !b[0]));
  endfunction
endpackage

// File: rtl/spd_bus_sync.sv
module spd_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/spd_mem.sv
module spd_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spd_protect.sv
module spd_protect
  import spd_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_req,
  input  logic req_lock,
  input  logic req_upper,
  input  logic wp,
  output logic commit,
  output logic lock,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] busy_cnt;

  assign commit = commit_req &&
                  (req_lock ? !lock : write_allowed(lock, wp, req_upper));
  assign busy   = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      lock     <= 1'b0;
    end else begin
      if (commit) busy_cnt <= CW'(BUSY_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (commit && req_lock) lock <= 1'b1;
    end
  end

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  p_busy_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));
  p_no_commit_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);
endmodule

// File: rtl/spd_eeprom_target.sv
module spd_eeprom_target
  import spd_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam logic [3:0] ACK_BIT = 4'(DW);
  localparam logic [3:0] END_BIT = 4'(DW + 1);

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic commit, lock, busy, mem_we, ack_now, dev_ack_ev;
  bus_state_t state;
  logic [3:0]    cnt;
  logic [DW-1:0] shreg, pend_data, rd_data;
  logic [AW-1:0] ptr, pend_addr;
  logic pend_valid, pend_lock, cur_rw, cur_lock, mnack, sda_oe_q;

  spd_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  spd_protect #(.BUSY_CYCLES(BUSY_CYCLES)) prot_i (
    .clk(clk), .rst_n(rst_n), .commit_req(stop_ev && pend_valid),
    .req_lock(pend_lock), .req_upper(pend_addr[AW-1]), .wp(wp_i),
    .commit(commit), .lock(lock), .busy(busy));

  spd_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(pend_addr),
    .wdata(pend_data), .raddr(ptr), .rdata(rd_data));

  assign mem_we     = commit && !pend_lock;
  assign ack_now    = dev_hit(shreg[7:0], sel_i) && !busy;
  assign dev_ack_ev = (state == ST_DEV) && scl_fall && (cnt == ACK_BIT) && ack_now;
  assign sda_oe_o   = sda_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; shreg <= '0; ptr <= '0;
      pend_addr <= '0; pend_data <= '0; pend_valid <= 1'b0; pend_lock <= 1'b0;
      cur_rw <= 1'b0; cur_lock <= 1'b0; mnack <= 1'b0; sda_oe_q <= 1'b0;
    end else if (start_ev) begin
      state <= ST_DEV; cnt <= '0; pend_valid <= 1'b0; sda_oe_q <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE; cnt <= '0; pend_valid <= 1'b0; sda_oe_q <= 1'b0;
    end else if (state != ST_IDLE && state != ST_HOLD) begin
      if (scl_rise) begin
        if (state == ST_TX) begin
          if (cnt == ACK_BIT) mnack <= sda_s;
        end else if (cnt < ACK_BIT) begin
          shreg <= {shreg[DW-2:0], sda_s};
        end
        cnt <= cnt + 4'd1;
      end
      if (scl_fall) begin
        unique case (state)
          ST_DEV: begin
            if (cnt == ACK_BIT) begin
              if (ack_now) begin
                sda_oe_q <= 1'b1;
                cur_rw   <= shreg[0];
                cur_lock <= (shreg[7:4] == CODE_LOCK);
              end else begin
                state <= ST_HOLD;
              end
            end else if (cnt == END_BIT) begin
              sda_oe_q <= 1'b0;
              cnt      <= '0;
              if (cur_lock) state <= ST_LOCKB;
              else if (cur_rw) begin
                state    <= ST_TX;
                sda_oe_q <= ~rd_data[DW-1];
              end else state <= ST_WORD;
            end
          end
          ST_WORD, ST_DATA, ST_LOCKB: begin
            if (cnt == ACK_BIT) begin
              sda_oe_q <= 1'b1;
              if (state == ST_WORD) ptr <= shreg[AW-1:0];
              if (state == ST_DATA) begin
                pend_addr <= ptr;
                pend_data <= shreg;
                ptr       <= ptr + 1'b1;
              end
              if (state != ST_WORD) begin
                pend_valid <= 1'b1;
                pend_lock  <= (state == ST_LOCKB);
              end
            end else if (cnt == END_BIT) begin
              sda_oe_q <= 1'b0;
              cnt      <= '0;
              state    <= (state == ST_WORD) ? ST_DATA : ST_HOLD;
            end
          end
          ST_TX: begin
            if (cnt == ACK_BIT) begin
              sda_oe_q <= 1'b0;
              ptr      <= ptr + 1'b1;
            end else if (cnt == END_BIT) begin
              if (mnack) state <= ST_HOLD;
              else begin
                cnt      <= '0;
                sda_oe_q <= ~rd_data[DW-1];
              end
            end else if (cnt != 4'd0) begin
              sda_oe_q <= ~rd_data[3'd7 - cnt[2:0]];
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_HOLD) |-> !sda_oe_o);
  p_commit_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> stop_ev);
  p_busy_deaf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dev_ack_ev);
  p_lock_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && lock) |-> pend_addr[AW-1]);
  p_wp_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wp_i) |-> !pend_addr[AW-1]);
endmodule

// File: tb/spd_eeprom_target_tb_top.sv
module spd_eeprom_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int BUSY       = 600;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] MEM_W  = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] MEM_R  = {4'b1010, SEL, 1'b1};
  localparam logic [7:0] LOCK_W = {4'b0110, SEL, 1'b0};
  localparam logic [7:0] LOCK_R = {4'b0110, SEL, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0;
  logic [7:0] rd_buf [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spd_eeprom_target #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sel_i(SEL), .wp_i(wp), .sda_oe_o(sda_oe));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(2);
  endtask
  task automatic wbit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(2); scl_m = 1'b0; q();
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask
  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = !b;
  endtask
  task automatic rbyte(output logic [7:0] v, input logic host_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(!host_ack);
  endtask

  task automatic probe(input logic [7:0] dev, output logic ack);
    bus_start(); wbyte(dev, ack); bus_stop();
  endtask
  task automatic mem_write(input logic [7:0] a, input logic [7:0] d, output logic all_ack);
    logic a1, a2, a3;
    bus_start(); wbyte(MEM_W, a1); wbyte(a, a2); wbyte(d, a3); bus_stop();
    all_ack = a1 & a2 & a3;
  endtask
  task automatic wait_busy();
    repeat (BUSY + 100) @(negedge clk);
  endtask
  task automatic rand_read(input logic [7:0] a, input int n);
    logic k;
    bus_start(); wbyte(MEM_W, k); wbyte(a, k);
    bus_start(); wbyte(MEM_R, k);
    for (int i = 0; i < n; i++) rbyte(rd_buf[i], i != n - 1);
    bus_stop();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 reset idle", sda_oe, 0);
  endtask

  task automatic t_no_start();
    logic b;
    scl_m = 1'b0; q();
    for (int i = 7; i >= 0; i--) wbit(MEM_W[i]);
    rbit(b);
    check(b == 1'b1, "R1 bits without start not acked", b, 1);
    bus_stop();
  endtask

  task automatic t_addressing();
    logic ack;
    probe({4'b1010, 3'b100, 1'b0}, ack);
    check(!ack, "R2 wrong select", ack, 0);
    probe({4'b1011, SEL, 1'b0}, ack);
    check(!ack, "R2 wrong code", ack, 0);
    probe(MEM_W, ack);
    check(ack, "R2 matching address", ack, 1);
    probe(LOCK_R, ack);
    check(!ack, "R11 lock code read", ack, 0);
  endtask

  task automatic t_write_busy_read();
    logic ack;
    mem_write(8'h10, 8'hA5, ack);
    check(ack, "R3 write acked", ack, 1);
    probe(MEM_W, ack);
    check(!ack, "R7 busy ignores address", ack, 0);
    wait_busy();
    probe(MEM_W, ack);
    check(ack, "R7 answers after busy", ack, 1);
    rand_read(8'h10, 1);
    check(rd_buf[0] == 8'hA5, "R4 random read", rd_buf[0], 8'hA5);
  endtask

  task automatic t_rep_start_discard();
    logic k;
    bus_start(); wbyte(MEM_W, k); wbyte(8'h20, k); wbyte(8'h3C, k);
    bus_start(); wbyte(MEM_W, k); bus_stop();
    probe(MEM_W, k);
    check(k, "R3 discarded write starts no busy", k, 1);
    rand_read(8'h20, 1);
    check(rd_buf[0] == 8'hFF, "R3 repeated start discards", rd_buf[0], 8'hFF);
  endtask

  task automatic t_extra_byte();
    logic k, a3;
    bus_start(); wbyte(MEM_W, k); wbyte(8'h30, k); wbyte(8'h12, k); wbyte(8'h34, a3);
    bus_stop();
    check(!a3, "R11 second data byte not acked", a3, 0);
    wait_busy();
    rand_read(8'h30, 1);
    check(rd_buf[0] == 8'h12, "R3 first byte kept", rd_buf[0], 8'h12);
  endtask

  task automatic t_seq_wrap();
    logic k;
    mem_write(8'hFE, 8'h11, k); wait_busy();
    mem_write(8'hFF, 8'h22, k); wait_busy();
    mem_write(8'h00, 8'h33, k); wait_busy();
    mem_write(8'h01, 8'h44, k); wait_busy();
    rand_read(8'hFE, 3);
    check(rd_buf[0] == 8'h11, "R5 seq byte 0", rd_buf[0], 8'h11);
    check(rd_buf[1] == 8'h22, "R5 seq byte 1", rd_buf[1], 8'h22);
    check(rd_buf[2] == 8'h33, "R5 seq wrap to 00", rd_buf[2], 8'h33);
    bus_start(); wbyte(MEM_R, k); rbyte(rd_buf[0], 1'b0); bus_stop();
    check(rd_buf[0] == 8'h44, "R6 current address read", rd_buf[0], 8'h44);
  endtask

  task automatic t_wp();
    logic ack;
    wp = 1'b1;
    mem_write(8'h90, 8'h77, ack);
    check(ack, "R10 blocked write acked", ack, 1);
    probe(MEM_W, ack);
    check(ack, "R10 blocked write no busy", ack, 1);
    rand_read(8'h90, 1);
    check(rd_buf[0] == 8'hFF, "R9 wp blocks upper", rd_buf[0], 8'hFF);
    wp = 1'b0;
    mem_write(8'h90, 8'h77, ack); wait_busy();
    rand_read(8'h90, 1);
    check(rd_buf[0] == 8'h77, "R9 wp low allows", rd_buf[0], 8'h77);
  endtask

  task automatic t_lock();
    logic a1, a2;
    mem_write(8'h05, 8'h5A, a1); wait_busy();
    rand_read(8'h05, 1);
    check(rd_buf[0] == 8'h5A, "R8 lower writable before lock", rd_buf[0], 8'h5A);
    bus_start(); wbyte(LOCK_W, a1); wbyte(8'h00, a2); bus_stop();
    check(a1 & a2, "R8 lock write acked", a1 & a2, 1);
    probe(MEM_W, a1);
    check(!a1, "R7 lock write starts busy", a1, 0);
    wait_busy();
    mem_write(8'h05, 8'h99, a1);
    probe(MEM_W, a2);
    check(a2, "R10 locked write no busy", a2, 1);
    rand_read(8'h05, 1);
    check(rd_buf[0] == 8'h5A, "R8 lower locked", rd_buf[0], 8'h5A);
    mem_write(8'h85, 8'h88, a1); wait_busy();
    rand_read(8'h85, 1);
    check(rd_buf[0] == 8'h88, "R8 upper unaffected by lock", rd_buf[0], 8'h88);
    bus_start(); wbyte(LOCK_W, a1); wbyte(8'h00, a2); bus_stop();
    probe(MEM_W, a2);
    check(a1 && a2, "R10 repeated lock acked, no busy", a1 && a2, 1);
    mem_write(8'h06, 8'h01, a1);
    rand_read(8'h06, 1);
    check(rd_buf[0] == 8'hFF, "R8 lock stays set", rd_buf[0], 8'hFF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_no_start();
    t_addressing();
    t_write_busy_read();
    t_rep_start_discard();
    t_extra_byte();
    t_seq_wrap();
    t_wp();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule